// File: doc/BRIEF.md
# Boundary Scan Cell Chain

This block is a serial chain of test cells placed between a core's functional pins and the chip pads. Every cell owns two storage stages: a capture/shift stage that sits on the serial path, and an update stage that can drive the functional side. With the test mode off, every pin passes straight through. With the test mode on, the pads and the core inputs are driven from the update stages. This lets an external controller force values onto the board wiring, or apply values to the core, while the serial path keeps working.

A test controller drives four controls: a data-register clock enable, a shift select, an update strobe and a mode select from instruction decode. These are enough for sample, preload and external-test sequences. Pin values are captured in parallel and then shifted out toward the serial output, while new data shifts in behind them. The new data is then copied into the update stages in one step. Tri-state pads share one extra enable cell. Its update value gates the pad enable.

Top module: `bscan_chain`

## Requirements
- R1: After reset is asserted (rst_n low), every capture/shift stage and every update stage reads 0. With mode_ctl=1, tdo, pad_out, pad_oe and core_in are therefore all 0.
- R2: With mode_ctl=0, pad_out equals core_out, pad_oe equals core_oe and core_in equals pad_in, combinationally, whatever the stored state is.
- R3: On a rising clk edge with clock_dr=1 and shift_dr=1, each capture/shift stage takes the value of its neighbour nearer tdi. The top cell (index LEN-1, LEN = N_IN+N_OUT+1) takes tdi, and tdo always shows the stage of cell 0. The first bit shifted in therefore reaches tdo after LEN shifts.
- R4: On a rising clk edge with clock_dr=1 and shift_dr=0, each cell captures its functional input. Cell 0 takes core_oe. Cell 1+j takes core_out[j]. Cell N_OUT+1+k takes pad_in[k].
- R5: On a rising clk edge with update_dr=1, every update stage copies its cell's capture/shift stage. Then, with mode_ctl=1, pad_out[j] shows cell 1+j and core_in[k] shows cell N_OUT+1+k.
- R6: Update stages hold their value on every edge without update_dr. Test-mode outputs stay stable through capture and shift.
- R7: With clock_dr=0, the capture/shift stages hold their value, even when shift_dr=1.
- R8: With mode_ctl=1, pad_oe is driven by the update stage of cell 0, the tri-state enable cell.
- R9: When update_dr and clock_dr are both 1 on one edge, the update stages receive the capture/shift values from before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock; all stages change on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of all stages |
| clock_dr | input | 1 | Enables capture or shift of the capture/shift stages |
| shift_dr | input | 1 | 1 selects serial shift, 0 selects parallel capture |
| update_dr | input | 1 | Copies capture/shift stages into update stages |
| mode_ctl | input | 1 | 0 passes functional values, 1 drives from update stages |
| tdi | input | 1 | Serial data entering the top cell |
| tdo | output | 1 | Serial data leaving cell 0 |
| core_out | input | N_OUT | Functional outputs of the core |
| core_oe | input | 1 | Functional tri-state enable of the core |
| pad_out | output | N_OUT | Values toward the output pads |
| pad_oe | output | 1 | Enable toward the tri-state output pads |
| pad_in | input | N_IN | Values arriving from the input pads |
| core_in | output | N_IN | Values toward the core inputs |

## Verification
A wrong capture/shift bit becomes visible on tdo within LEN shift cycles of the next unload. A stuck or misrouted stage shows up as a specific wrong bit in the unloaded word. A wrong update stage is visible on pad_out, pad_oe or core_in as soon as mode_ctl is 1, one cycle after the update strobe. A leak of the shift path into the update stages shows up as outputs that move during a shift. The bench sweeps every 8-bit chain word through shift, update and unload, every capture pattern, and every pass-through pattern, so each cell is compared to its own arithmetic expectation.

// File: rtl/bscan_pkg.sv
package bscan_pkg;

   typedef enum logic [1:0] {
      CELL_OE  = 2'd0,
      CELL_OUT = 2'd1,
      CELL_IN  = 2'd2
   } cell_kind_e;

   // cell 0 is the enable cell, then output cells, then input cells nearest tdi
   function automatic cell_kind_e kind_of(input int idx, input int n_out);
      if (idx == 0)          return CELL_OE;
      else if (idx <= n_out) return CELL_OUT;
      else                   return CELL_IN;
   endfunction

endpackage

// File: rtl/bscan_shift_stage.sv
module bscan_shift_stage (
   input  logic clk,
   input  logic rst_n,
   input  logic clock_dr,
   input  logic shift_dr,
   input  logic scan_in,
   input  logic func_in,
   output logic q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        q <= 1'b0;
      else if (clock_dr) q <= shift_dr ? scan_in : func_in;
   end

   AST_SHIFT_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
      (clock_dr && shift_dr) |=> (q == $past(scan_in))); // R3
   AST_CAPTURE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (clock_dr && !shift_dr) |=> (q == $past(func_in))); // R4
   AST_SHIFT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !clock_dr |=> $stable(q)); // R7

endmodule

// File: rtl/bscan_update_stage.sv
module bscan_update_stage (
   input  logic clk,
   input  logic rst_n,
   input  logic update_dr,
   input  logic d,
   output logic q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         q <= 1'b0;
      else if (update_dr) q <= d;
   end

   AST_UPD_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      update_dr |=> (q == $past(d))); // R5
   AST_UPD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !update_dr |=> $stable(q)); // R6

endmodule

// File: rtl/bscan_chain.sv
module bscan_chain
   import bscan_pkg::*;
#(
   parameter int N_IN  = 3,
   parameter int N_OUT = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clock_dr,
   input  logic             shift_dr,
   input  logic             update_dr,
   input  logic             mode_ctl,
   input  logic             tdi,
   output logic             tdo,
   input  logic [N_OUT-1:0] core_out,
   input  logic             core_oe,
   output logic [N_OUT-1:0] pad_out,
   output logic             pad_oe,
   input  logic [N_IN-1:0]  pad_in,
   output logic [N_IN-1:0]  core_in
);

   localparam int LEN      = N_IN + N_OUT + 1;
   localparam int IN_BASE  = N_OUT + 1;
   localparam int OUT_BASE = 1;

   if (N_IN < 1)    begin : g_chk_in   $error("N_IN must be at least 1");   end
   if (N_OUT < 1)   begin : g_chk_out  $error("N_OUT must be at least 1");  end
   if (LEN > 4096)  begin : g_chk_len  $error("chain too long");            end

   logic [LEN-1:0] func_src;
   logic [LEN-1:0] scan_src;
   logic [LEN-1:0] sh_q;
   logic [LEN-1:0] up_q;
   logic [LEN-1:0] drive;

   assign func_src = {pad_in, core_out, core_oe};
   if (LEN > 1) begin : g_scan_multi
      assign scan_src = {tdi, sh_q[LEN-1:1]};
   end else begin : g_scan_single
      assign scan_src = tdi;
   end
   assign tdo = sh_q[0];

   for (genvar i = 0; i < LEN; i++) begin : g_cell
      bscan_shift_stage u_shift (
         .clk      (clk),
         .rst_n    (rst_n),
         .clock_dr (clock_dr),
         .shift_dr (shift_dr),
         .scan_in  (scan_src[i]),
         .func_in  (func_src[i]),
         .q        (sh_q[i])
      );
      bscan_update_stage u_update (
         .clk       (clk),
         .rst_n     (rst_n),
         .update_dr (update_dr),
         .d         (sh_q[i]),
         .q         (up_q[i])
      );
      assign drive[i] = mode_ctl ? up_q[i] : func_src[i];

      if (kind_of(i, N_OUT) == CELL_OE) begin : g_oe
         assign pad_oe = drive[i];
      end else if (kind_of(i, N_OUT) == CELL_OUT) begin : g_out
         assign pad_out[i-OUT_BASE] = drive[i];
      end else begin : g_in
         assign core_in[i-IN_BASE] = drive[i];
      end
   end

   AST_PASS_THRU: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_ctl |-> (pad_out == core_out && core_in == pad_in && pad_oe == core_oe)); // R2
   AST_TDO_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (clock_dr && shift_dr) |=> (tdo == $past(sh_q[OUT_BASE % LEN]) || LEN == 1)); // R3
   AST_OE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_ctl && $stable(mode_ctl) && !$past(update_dr)) |-> $stable(pad_oe)); // R8

endmodule

// File: tb/bscan_chain_tb_top.sv
`timescale 1ns/1ps
module bscan_chain_tb_top;

   localparam int NI  = 3;
   localparam int NO  = 4;
   localparam int LEN = NI + NO + 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic clock_dr = 1'b0, shift_dr = 1'b0, update_dr = 1'b0, mode_ctl = 1'b0, tdi = 1'b0;
   logic tdo;
   logic [NO-1:0] core_out = '0;
   logic          core_oe  = 1'b0;
   logic [NO-1:0] pad_out;
   logic          pad_oe;
   logic [NI-1:0] pad_in = '0;
   logic [NI-1:0] core_in;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #4 clk = ~clk;

   bscan_chain #(.N_IN(NI), .N_OUT(NO)) dut_i (
      .clk(clk), .rst_n(rst_n), .clock_dr(clock_dr), .shift_dr(shift_dr),
      .update_dr(update_dr), .mode_ctl(mode_ctl), .tdi(tdi), .tdo(tdo),
      .core_out(core_out), .core_oe(core_oe), .pad_out(pad_out), .pad_oe(pad_oe),
      .pad_in(pad_in), .core_in(core_in)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   function automatic logic [LEN-1:0] out_word();
      return {core_in, pad_out, pad_oe};
   endfunction

   // shift w in (bit 0 first) while unloading the chain into got
   task automatic shift_word(input logic [LEN-1:0] w, output logic [LEN-1:0] got,
                             input logic [LEN-1:0] hold_exp, input bit chk_hold);
      for (int k = 0; k < LEN; k++) begin
         got[k]   = tdo;
         tdi      = w[k];
         clock_dr = 1'b1;
         shift_dr = 1'b1;
         tick();
         if (chk_hold)
            check(out_word() == hold_exp, "R6", int'(out_word()), int'(hold_exp));
      end
      clock_dr = 1'b0;
      shift_dr = 1'b0;
   endtask

   task automatic do_update();
      update_dr = 1'b1;
      tick();
      update_dr = 1'b0;
   endtask

   initial begin
      logic [LEN-1:0] got;
      logic [LEN-1:0] upd_exp;
      @(negedge clk);
      tick();
      // R1: reset state
      mode_ctl = 1'b1;
      #1;
      check(tdo == 1'b0, "R1", tdo, 0);
      check(out_word() == '0, "R1", int'(out_word()), 0);
      rst_n = 1'b1;
      tick();

      // R2: pass-through sweep
      mode_ctl = 1'b0;
      for (int v = 0; v < 256; v++) begin
         {pad_in, core_out, core_oe} = v[LEN-1:0];
         #1;
         check(pad_out == core_out && pad_oe == core_oe && core_in == pad_in, "R2",
               int'(out_word()), v);
      end

      // R3 R5 R8 R6: load, update, unload every word
      mode_ctl = 1'b1;
      upd_exp  = '0;
      shift_word(LEN'(0), got, upd_exp, 1'b1);
      for (int v = 0; v < 256; v++) begin
         shift_word(v[LEN-1:0], got, upd_exp, 1'b1);
         do_update();
         upd_exp = v[LEN-1:0];
         check(pad_oe == v[0], "R8", pad_oe, v & 1);
         check(pad_out == v[NO:1] && core_in == v[LEN-1:NO+1], "R5",
               int'(out_word()), v);
         shift_word(v[LEN-1:0], got, upd_exp, 1'b1);
         check(got == v[LEN-1:0], "R3", int'(got), v);
      end

      // R7: shift_dr without clock_dr keeps the chain
      shift_word(8'hA5, got, upd_exp, 1'b0);
      shift_dr = 1'b1;
      tdi      = 1'b1;
      repeat (5) tick();
      shift_dr = 1'b0;
      shift_word(8'h00, got, upd_exp, 1'b0);
      check(got == 8'hA5, "R7", int'(got), 8'hA5);

      // R4 R6: capture sweep with test mode on
      do_update();
      upd_exp = '0;
      for (int v = 0; v < 256; v++) begin
         {pad_in, core_out, core_oe} = v[LEN-1:0];
         clock_dr = 1'b1;
         shift_dr = 1'b0;
         tick();
         clock_dr = 1'b0;
         check(out_word() == upd_exp, "R6", int'(out_word()), int'(upd_exp));
         shift_word(LEN'(0), got, upd_exp, 1'b0);
         check(got == v[LEN-1:0], "R4", int'(got), v);
      end

      // R9: capture and update on the same edge
      shift_word(8'h3C, got, upd_exp, 1'b0);
      {pad_in, core_out, core_oe} = 8'hC3;
      clock_dr  = 1'b1;
      update_dr = 1'b1;
      tick();
      clock_dr  = 1'b0;
      update_dr = 1'b0;
      check(out_word() == 8'h3C, "R9", int'(out_word()), 8'h3C);
      shift_word(LEN'(0), got, upd_exp, 1'b0);
      check(got == 8'hC3, "R9", int'(got), 8'hC3);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

endmodule